// File: doc/BRIEF.md
# Byte-Write Sequencer with Completion Polling

This block is a host-side bus master for a byte-wide parallel memory whose writes are timed inside the memory itself. A request carries an address, a data byte and a completion-mode select. The block first drives the write strobe sequence on active-low chip-enable, output-enable and write-enable lines. It then finds out when the memory has finished. No fixed wait is used.

There are two ways to detect completion. In polling mode the block re-reads the written address until bit 7 of the returned byte equals bit 7 of the byte written. While the write is in progress, the memory returns that bit inverted. In ready/busy mode the block watches the memory's ready line: it first waits for the line to go low, then for it to return high. The data bus is a split tri-state: an output byte, an output-enable and an input byte, which meet at the pad.

States and transitions:
- `ST_IDLE` goes to `ST_SETUP` on a request.
- `ST_SETUP` goes to `ST_WE_LOW`, which goes to `ST_WE_HIGH`.
- In polling mode, `ST_WE_HIGH` goes to `ST_BUS_REL`. From there the loop is `ST_BUS_REL` to `ST_POLL_READ` to `ST_POLL_CHECK`, and back to `ST_BUS_REL` on a bit-7 mismatch.
- In ready/busy mode, `ST_WE_HIGH` goes to `ST_WAIT_BUSY`.
- `ST_POLL_CHECK`, `ST_WAIT_BUSY` or a timeout goes to `ST_DONE`, which always returns to `ST_IDLE`.

Top module: `bytewr_seq`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are high, `mem_dq_oe` is low, and `done`, `ok` and `timeout_err` are low.
- R2: A request accepted in idle produces three phases, all with CE low, address driven and `mem_dq_oe` high:
  - SETUP_CLK clocks with OE high and WE high;
  - then WE_CLK clocks with WE low;
  - then HOLD_CLK clocks with WE high again.
- R3: OE is high in every clock where WE is low. The address does not change while WE is low. The data byte is still driven, and unchanged, in the clock after WE rises.
- R4: Before every poll read there is exactly one clock with `mem_dq_oe` low and OE high. `mem_dq_oe` is never high while OE is low.
- R5: A poll read holds CE and OE low with WE high for ACC_CLK clocks plus one compare clock, and samples the data in that compare clock. If bit 7 of the sample differs from bit 7 of the written byte, the poll read is repeated after a new release clock.
- R6: On a bit-7 match, `ST_DONE` follows. `ok` is 1 only if all 8 sampled bits equal the written byte. `timeout_err` is 0.
- R7: In ready/busy mode (`req_busy_mode`=1), `mem_rdy` must first be seen low and later high. On the first high clock after a low one, the block completes with `ok`=1.
- R8: If the TMO_CLK-th clock spent in the completion phase (release, poll read, compare or busy wait) does not complete, the block ends with `timeout_err`=1 and `ok`=0. This includes a ready line that never goes low.
- R9: CE is high (standby) in idle, in the release clock, during the busy wait and in `ST_DONE`.
- R10: `req_valid` and the request fields are ignored while a request is in progress. The address and data on the memory bus keep the accepted values.
- R11: `done` is high for exactly one clock per request, and the block is idle on the next clock. `ok` and `timeout_err` keep their value until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a byte write (accepted in idle only) |
| req_addr | input | AW | Target address |
| req_data | input | 8 | Byte to write |
| req_busy_mode | input | 1 | 1: use ready line; 0: bit-7 polling |
| done | output | 1 | One-clock completion pulse |
| ok | output | 1 | Write verified (valid with done, held after) |
| timeout_err | output | 1 | Completion not seen within TMO_CLK clocks |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | AW | Memory address bus |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Tri-state enable for mem_dq_out |
| mem_dq_in | input | 8 | Data read from the memory |
| mem_rdy | input | 1 | Memory ready line, low while a write is in progress |

## Verification
The hardest case to reach is completion racing the timeout. This needs a write still in progress on the exact clock the completion counter expires, and a ready line that never falls. A behavioural memory in the bench has a programmable write time and an option for a late or absent busy indication, so both timeout paths are forced. A second memory option stores a byte that keeps bit 7 but flips a low bit. This drives the path where polling succeeds but the full compare reports failure. A request pulse injected in mid-write shows that the bus keeps the accepted address.

// File: rtl/bwr_pkg.sv
package bwr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WE_LOW,
        ST_WE_HIGH,
        ST_BUS_REL,
        ST_POLL_READ,
        ST_POLL_CHECK,
        ST_WAIT_BUSY,
        ST_DONE
    } bwr_state_e;

endpackage

// File: rtl/bwr_cnt.sv
module bwr_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (en) begin
            q <= q + 1'b1;
        end
    end

endmodule

// File: rtl/bwr_cmp.sv
module bwr_cmp (
    input  logic [7:0] rd_byte,
    input  logic [7:0] wr_byte,
    output logic       msb_match,
    output logic       full_match
);

    assign msb_match  = (rd_byte[7] == wr_byte[7]);
    assign full_match = (rd_byte == wr_byte);

endmodule

// File: rtl/bytewr_seq.sv
module bytewr_seq
    import bwr_pkg::*;
#(
    parameter int AW        = 13,
    parameter int SETUP_CLK = 1,
    parameter int WE_CLK    = 4,
    parameter int HOLD_CLK  = 1,
    parameter int ACC_CLK   = 3,
    parameter int TMO_CLK   = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    input  logic          req_busy_mode,
    output logic          done,
    output logic          ok,
    output logic          timeout_err,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [7:0]    mem_dq_in,
    input  logic          mem_rdy
);

    localparam int PH_MAX = (SETUP_CLK > WE_CLK ? SETUP_CLK : WE_CLK) >
                            (HOLD_CLK > ACC_CLK ? HOLD_CLK : ACC_CLK) ?
                            (SETUP_CLK > WE_CLK ? SETUP_CLK : WE_CLK) :
                            (HOLD_CLK > ACC_CLK ? HOLD_CLK : ACC_CLK);
    localparam int PH_W  = $clog2(PH_MAX + 1);
    localparam int TMO_W = $clog2(TMO_CLK + 1);

    bwr_state_e     state_q, state_n;
    logic [AW-1:0]  addr_q;
    logic [7:0]     data_q;
    logic           mode_q;
    logic           seen_low_q;
    logic           ok_q, err_q;

    logic [PH_W-1:0]  ph_cnt;
    logic [TMO_W-1:0] tmo_cnt;
    int               ph_len;
    logic             ph_last;
    logic             in_wait;
    logic             tmo_hit;
    logic             msb_match, full_match;
    logic             busy_cycle_done;
    logic             finish_good, finish_ok;

    // phase length timer, restarted on every state change
    bwr_cnt #(.W(PH_W)) u_ph_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_n != state_q),
        .en    (1'b1),
        .q     (ph_cnt)
    );

    // completion timeout, runs only in the completion phase
    bwr_cnt #(.W(TMO_W)) u_tmo_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!in_wait),
        .en    (in_wait),
        .q     (tmo_cnt)
    );

    bwr_cmp u_cmp (
        .rd_byte    (mem_dq_in),
        .wr_byte    (data_q),
        .msb_match  (msb_match),
        .full_match (full_match)
    );

    always_comb begin
        unique case (state_q)
            ST_SETUP:     ph_len = SETUP_CLK;
            ST_WE_LOW:    ph_len = WE_CLK;
            ST_WE_HIGH:   ph_len = HOLD_CLK;
            ST_POLL_READ: ph_len = ACC_CLK;
            default:      ph_len = 1;
        endcase
    end

    assign ph_last = (int'(ph_cnt) == ph_len - 1);
    assign in_wait = (state_q == ST_BUS_REL) || (state_q == ST_POLL_READ) ||
                     (state_q == ST_POLL_CHECK) || (state_q == ST_WAIT_BUSY);
    assign tmo_hit = in_wait && (int'(tmo_cnt) == TMO_CLK - 1);
    assign busy_cycle_done = (state_q == ST_WAIT_BUSY) && seen_low_q && mem_rdy;
    assign finish_good = busy_cycle_done || ((state_q == ST_POLL_CHECK) && msb_match);
    assign finish_ok   = busy_cycle_done || full_match;

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:       if (req_valid) state_n = ST_SETUP;
            ST_SETUP:      if (ph_last) state_n = ST_WE_LOW;
            ST_WE_LOW:     if (ph_last) state_n = ST_WE_HIGH;
            ST_WE_HIGH:    if (ph_last) state_n = mode_q ? ST_WAIT_BUSY : ST_BUS_REL;
            ST_BUS_REL:    state_n = tmo_hit ? ST_DONE : ST_POLL_READ;
            ST_POLL_READ:  if (tmo_hit) state_n = ST_DONE;
                           else if (ph_last) state_n = ST_POLL_CHECK;
            ST_POLL_CHECK: state_n = (msb_match || tmo_hit) ? ST_DONE : ST_BUS_REL;
            ST_WAIT_BUSY:  if (busy_cycle_done || tmo_hit) state_n = ST_DONE;
            ST_DONE:       state_n = ST_IDLE;
            default:       state_n = ST_IDLE;
        endcase
    end

    // state and request registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            addr_q     <= '0;
            data_q     <= '0;
            mode_q     <= 1'b0;
            seen_low_q <= 1'b0;
            ok_q       <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            state_q <= state_n;
            if (state_q == ST_IDLE && req_valid) begin
                addr_q     <= req_addr;
                data_q     <= req_data;
                mode_q     <= req_busy_mode;
                seen_low_q <= 1'b0;
                ok_q       <= 1'b0;
                err_q      <= 1'b0;
            end
            if (state_q == ST_WAIT_BUSY && !mem_rdy) begin
                seen_low_q <= 1'b1;
            end
            if (state_n == ST_DONE && state_q != ST_DONE) begin
                ok_q  <= finish_good && finish_ok;
                err_q <= !finish_good;
            end
        end
    end

    // memory strobes and data bus enable
    always_comb begin
        mem_ce_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state_q)
            ST_SETUP, ST_WE_HIGH: begin
                mem_ce_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_WE_LOW: begin
                mem_ce_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_POLL_READ, ST_POLL_CHECK: begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            default: begin
                mem_ce_n = 1'b1;
            end
        endcase
    end

    assign mem_addr    = addr_q;
    assign mem_dq_out  = data_q;
    assign done        = (state_q == ST_DONE);
    assign ok          = ok_q;
    assign timeout_err = err_q;

endmodule

// File: rtl/bwr_chk.sv
module bwr_chk #(
    parameter int AW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          ok,
    input logic          timeout_err,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic [AW-1:0] mem_addr,
    input logic [7:0]    mem_dq_out,
    input logic          mem_dq_oe
);

    // R3
    oe_high_while_we_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // R3
    addr_steady_we_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_addr));

    // R3
    data_hold_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n && $stable(mem_dq_out)));

    // R4
    no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    // R4
    release_before_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> ($past(!mem_dq_oe) && $past(mem_ce_n)));

    // R11
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    result_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(ok && timeout_err));

    // R9
    standby_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mem_ce_n && mem_we_n && mem_oe_n));

endmodule

bind bytewr_seq bwr_chk #(.AW(AW)) u_chk (.*);

// File: tb/bytewr_seq_tb.sv
module bytewr_seq_tb;

    localparam int AW        = 13;
    localparam int SETUP_CLK = 2;
    localparam int WE_CLK    = 4;
    localparam int HOLD_CLK  = 1;
    localparam int ACC_CLK   = 3;
    localparam int TMO_CLK   = 300;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic [7:0]    req_data;
    logic          req_busy_mode;
    logic          done, ok, timeout_err;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_dq_out;
    logic [7:0]    mem_dq_in;
    logic          mem_rdy;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bytewr_seq #(
        .AW(AW), .SETUP_CLK(SETUP_CLK), .WE_CLK(WE_CLK),
        .HOLD_CLK(HOLD_CLK), .ACC_CLK(ACC_CLK), .TMO_CLK(TMO_CLK)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_busy_mode(req_busy_mode), .done(done),
        .ok(ok), .timeout_err(timeout_err), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
        .mem_rdy(mem_rdy)
    );

    // behavioural self-timed memory
    logic [7:0]    mem [0:255];
    int            busy_left = 0;
    int            wtime = 0;
    bit            corrupt = 0;
    logic          prev_we = 1'b1;
    logic [AW-1:0] lat_addr = '0;
    logic [7:0]    pend = '0;
    logic [7:0]    rd_val;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    end

    always @(posedge clk) begin
        prev_we <= mem_we_n;
        if (prev_we && !mem_we_n) lat_addr <= mem_addr;
        if (!prev_we && mem_we_n && !mem_ce_n && mem_dq_oe) begin
            mem[lat_addr[7:0]] <= corrupt ? (mem_dq_out ^ 8'h04) : mem_dq_out;
            pend      <= mem_dq_out;
            busy_left <= wtime;
        end else if (busy_left > 0) begin
            busy_left <= busy_left - 1;
        end
    end

    always_comb begin
        rd_val = (busy_left != 0 && mem_addr == lat_addr) ? {~pend[7], 7'h2A}
                                                          : mem[mem_addr[7:0]];
        mem_dq_in = (!mem_ce_n && !mem_oe_n) ? rd_val : 8'h00;
        mem_rdy   = (busy_left == 0);
    end

    task automatic check(input bit cond, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // compare strobes {ce,oe,we,dq_oe}, done, address and driven data
    task automatic expect_cyc(input logic [3:0] ctl, input logic dn,
                              input logic [AW-1:0] ea, input logic [7:0] ed,
                              input string tag);
        logic [3:0] act;
        act = {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe};
        check(act == ctl, tag, "ce/oe/we/dq_oe", int'(act), int'(ctl));
        check(done == dn, tag, "done", int'(done), int'(dn));
        if (!mem_ce_n) check(mem_addr == ea, tag, "addr", int'(mem_addr), int'(ea));
        if (mem_dq_oe) check(mem_dq_out == ed, tag, "dq_out", int'(mem_dq_out), int'(ed));
    endtask

    task automatic run_write(input logic [AW-1:0] a, input logic [7:0] d,
                             input bit busy_mode, input bit inj,
                             input bit exp_timeout, input string tag);
        int  w;
        bit  fin, good, exp_ok, seen;
        w = 0; fin = 0; good = 0; exp_ok = 0; seen = 0;
        req_addr = a; req_data = d; req_busy_mode = busy_mode; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < SETUP_CLK; i++) begin
            if (inj && i == 0) begin
                req_valid = 1'b1; req_addr = a ^ 13'h1; req_data = ~d;
            end
            expect_cyc(4'b0111, 1'b0, a, d, "R2");
            @(negedge clk);
            req_valid = 1'b0;
        end
        if (inj) expect_cyc(4'b0101, 1'b0, a, d, "R10");
        for (int i = 0; i < WE_CLK; i++) begin
            expect_cyc(4'b0101, 1'b0, a, d, "R3");
            @(negedge clk);
        end
        for (int i = 0; i < HOLD_CLK; i++) begin
            expect_cyc(4'b0111, 1'b0, a, d, "R2");
            @(negedge clk);
        end
        if (!busy_mode) begin
            while (!fin) begin
                w++;
                expect_cyc(4'b1110, 1'b0, a, d, "R4");
                if (w == TMO_CLK) fin = 1;
                @(negedge clk);
                for (int i = 0; i < ACC_CLK; i++) begin
                    if (!fin) begin
                        w++;
                        expect_cyc(4'b0010, 1'b0, a, d, "R5");
                        if (w == TMO_CLK) fin = 1;
                        @(negedge clk);
                    end
                end
                if (!fin) begin
                    w++;
                    expect_cyc(4'b0010, 1'b0, a, d, "R5");
                    if (mem_dq_in[7] == d[7]) begin
                        fin = 1; good = 1; exp_ok = (mem_dq_in == d);
                    end else if (w == TMO_CLK) begin
                        fin = 1;
                    end
                    @(negedge clk);
                end
            end
        end else begin
            while (!fin) begin
                w++;
                expect_cyc(4'b1110, 1'b0, a, d, "R9");
                if (seen && mem_rdy) begin
                    fin = 1; good = 1; exp_ok = 1;
                end else if (w == TMO_CLK) begin
                    fin = 1;
                end
                if (!mem_rdy) seen = 1;
                @(negedge clk);
            end
        end
        expect_cyc(4'b1110, 1'b1, a, d, "R11");
        check(ok == (good && exp_ok), tag, "ok", int'(ok), int'(good && exp_ok));
        check(timeout_err == !good, tag, "timeout_err", int'(timeout_err), int'(!good));
        check(good == !exp_timeout, tag, "completion kind", int'(good), int'(!exp_timeout));
        @(negedge clk);
        expect_cyc(4'b1110, 1'b0, a, d, "R11");
        check(ok == (good && exp_ok), "R11", "ok held", int'(ok), int'(good && exp_ok));
        check(timeout_err == !good, "R11", "err held", int'(timeout_err), int'(!good));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_data = '0; req_busy_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe} == 4'b1110, "R1", "strobes",
              int'({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}), 14);
        check({done, ok, timeout_err} == 3'b000, "R1", "status",
              int'({done, ok, timeout_err}), 0);
        @(negedge clk);

        // R5 R6 polling, bit 7 set, several poll rounds
        wtime = 12; corrupt = 0;
        run_write(13'h012, 8'hA5, 1'b0, 1'b0, 1'b0, "R6");
        // R5 polling, bit 7 clear
        wtime = 7;
        run_write(13'h0C3, 8'h3C, 1'b0, 1'b0, 1'b0, "R6");
        // R5 write that is already complete at the first compare
        wtime = 0;
        run_write(13'h044, 8'h80, 1'b0, 1'b0, 1'b0, "R5");
        // R6 bit 7 matches but a low bit is wrong: ok must be 0
        wtime = 9; corrupt = 1;
        run_write(13'h055, 8'hF0, 1'b0, 1'b0, 1'b0, "R6");
        corrupt = 0;
        // R10 request pulse during the write is ignored
        wtime = 5;
        run_write(13'h066, 8'h5A, 1'b0, 1'b1, 1'b0, "R10");
        // R7 ready/busy mode
        wtime = 10;
        run_write(13'h077, 8'h81, 1'b1, 1'b0, 1'b0, "R7");
        // R8 ready line never falls
        wtime = 0;
        run_write(13'h088, 8'h11, 1'b1, 1'b0, 1'b1, "R8");
        // R8 polling never completes
        wtime = 50000;
        run_write(13'h099, 8'hC3, 1'b0, 1'b0, 1'b1, "R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule